// File: doc/BRIEF.md
# Multi-Mode Interval Timer Channel

This block is a single 16-bit down-counting timer channel. Software picks one of seven behaviours through a mode register, then writes a start value N through a small register port. The channel counts ticks and drives an output pin and an interrupt request according to the selected behaviour. The supported behaviours are a terminal-count interrupt, a retriggerable one-shot, a divide-by-N rate generator, a square wave, a strobe started by software and a strobe started by a trigger edge, plus an event counter. The live count appears on a read port in every cycle.

A tick normally comes from the clock-enable input. When the cascade bit of the mode register is set, the tick comes from the cascade input instead. Feeding another channel's output into that input chains channels into a prescaler. In event-counting mode, each rising edge on the gate input is one tick. The register port is a plain write strobe with an address. It has no back-pressure: every write takes effect at the clock edge that samples it. A start value of zero stands for 65536 ticks.

Top module: `prog_interval_timer`

## Requirements
- R1: After reset the count is 0, the output is high and the interrupt request is low. The read port shows the current count in every cycle.
- R2: Mode code 0 (terminal-count interrupt): a count write loads N and starts the channel, and the output goes low. On the Nth tick after the load, the count becomes 0, the output goes high and the interrupt request is high for exactly one clock. The count then holds at 0.
- R3: Mode code 1 (one-shot): a count write only stores N. A trigger loads N and drives the output low. A trigger is a write to address 2 or a rising edge on the gate input. The output goes high when the count reaches 0. A trigger that arrives while the channel is running reloads N.
- R4: Mode code 2 (rate generator): after a load the output is low only while the count is 1. The tick that arrives at a count of 1 reloads N, so the output is low for one tick in every N.
- R5: Mode code 3 (square wave): the output is high while the count (zero read as 65536) is greater than floor(N/2), and low otherwise. The count reloads N after each full pass. For an odd N, the high phase is one tick longer than the low phase.
- R6: Mode code 4 (software strobe): after a count write the output stays high. On the Nth tick the count becomes 0 and the output goes low until the next tick. The output then returns high and the channel stops.
- R7: Mode code 5 (hardware strobe): a count write only stores N. A rising edge on the gate input loads N and starts the strobe sequence of R6. A rising edge that arrives before the strobe restarts the sequence.
- R8: With mode bit 3 clear, a tick is a clock in which the clock-enable input is high. With mode bit 3 set, a tick is a clock in which the cascade input is high. Without a tick the count holds.
- R9: Mode code 6 (event counter): a count write loads N and starts the channel. Each rising edge on the gate input is one tick, and the clock-enable input is ignored. After N edges the output goes high and the interrupt request pulses for one clock. No mode other than 0 and 6 raises the interrupt request.
- R10: Address 0 writes the mode register: bits 2:0 are the mode code and bit 3 selects the cascade source. Code 7 is stored as code 0. A mode write stops the channel and drives the output high, and the count holds its value.
- R11: A start value of 0 counts 65536 ticks: the count reads 0xFFFF after the first tick and reaches terminal count on the 65536th tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 count, 2 software trigger |
| wr_data | input | 16 | Write data |
| cnt_en | input | 1 | Clock-enable tick source |
| casc_in | input | 1 | Cascade tick source from another channel |
| gate_in | input | 1 | Gate input: trigger edge or event source |
| rd_count | output | 16 | Live count |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request pulse |

## Verification
The assertions assume that the gate, cascade and clock-enable inputs are already synchronous to the clock. A gate rising edge is detected against the previous cycle's sampled value, so the gate must stay low for at least one clock between edges. The assertions also assume that address 3 is never written. The stimulus changes every input only on the falling clock edge. It pulses the gate and cascade inputs high for single clocks with low gaps between them, and it uses only addresses 0 to 2.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int REG_AW = 2;
  localparam logic [REG_AW-1:0] ADDR_MODE  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_COUNT = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_TRIG  = 2'd2;
  localparam int CASC_BIT = 3;

  typedef enum logic [2:0] {
    M_TCINT   = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5,
    M_EVENT   = 3'd6
  } tmr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RUN    = 2'd1,
    ST_STROBE = 2'd2
  } tmr_state_e;
endpackage

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl import ptimer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  output tmr_mode_e         mode,
  output logic              casc_sel,
  output logic [CNT_W-1:0]  reload,
  output logic              mode_wr,
  output logic              count_wr,
  output logic              sw_trig
);
  assign mode_wr  = wr_en && (wr_addr == ADDR_MODE);
  assign count_wr = wr_en && (wr_addr == ADDR_COUNT);
  assign sw_trig  = wr_en && (wr_addr == ADDR_TRIG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_TCINT;
      casc_sel <= 1'b0;
      reload   <= '0;
    end else begin
      if (mode_wr) begin
        mode     <= (wr_data[2:0] == 3'd7) ? M_TCINT : tmr_mode_e'(wr_data[2:0]);
        casc_sel <= wr_data[CASC_BIT];
      end
      if (count_wr) reload <= wr_data;
    end
  end
endmodule

// File: rtl/ptimer_tick.sv
module ptimer_tick import ptimer_pkg::*; (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cnt_en,
  input  logic      casc_in,
  input  logic      gate_in,
  input  logic      casc_sel,
  input  tmr_mode_e mode,
  output logic      tick,
  output logic      gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate_in;
  end

  assign gate_rise = gate_in && !gate_q;

  always_comb begin
    if (mode == M_EVENT) tick = gate_rise;
    else if (casc_sel)   tick = casc_in;
    else                 tick = cnt_en;
  end
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core import ptimer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tmr_mode_e        mode,
  input  logic [CNT_W-1:0] reload,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             mode_wr,
  input  logic             count_wr,
  input  logic             sw_trig,
  input  logic             gate_rise,
  input  logic             tick,
  output logic [CNT_W-1:0] count,
  output tmr_state_e       state,
  output logic             irq
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic waits_trigger, load, trig, at_end;

  assign waits_trigger = (mode == M_ONESHOT) || (mode == M_HWSTB);
  assign load   = count_wr && !waits_trigger;
  assign trig   = ((mode == M_ONESHOT) && (sw_trig || gate_rise)) ||
                  ((mode == M_HWSTB) && gate_rise);
  assign at_end = (count == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      state <= ST_IDLE;
      irq   <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (mode_wr) begin
        state <= ST_IDLE;
      end else if (load) begin
        count <= wr_data;
        state <= ST_RUN;
      end else if (trig) begin
        count <= reload;
        state <= ST_RUN;
      end else if (tick) begin
        case (state)
          ST_RUN: begin
            if (at_end) begin
              case (mode)
                M_TCINT, M_EVENT: begin
                  count <= '0;
                  state <= ST_IDLE;
                  irq   <= 1'b1;
                end
                M_RATE, M_SQUARE: count <= reload;
                M_SWSTB, M_HWSTB: begin
                  count <= '0;
                  state <= ST_STROBE;
                end
                default: begin
                  count <= '0;
                  state <= ST_IDLE;
                end
              endcase
            end else begin
              count <= count - ONE;
            end
          end
          ST_STROBE: state <= ST_IDLE;
          default: ;
        endcase
      end
    end
  end

  // R8: without a tick or a write the count does not move
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load && !trig) |=> $stable(count));

  // R2: the interrupt request lasts one clock
  assert_irq_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R9: only the interrupt and event modes raise a request
  assert_irq_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mode == M_TCINT || mode == M_EVENT));

  // R4: the rate generator reloads after the tick at count 1
  assert_rate_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RUN && mode == M_RATE && tick && at_end && !mode_wr && !load && !trig)
      |=> (count == $past(reload)));

  // R6: the strobe phase persists until a tick
  assert_strobe_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STROBE && !tick && !mode_wr && !load && !trig) |=> (state == ST_STROBE));

  // R3: a trigger reloads the stored value and starts the run
  assert_trig_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !mode_wr && !load) |=> (count == $past(reload) && state == ST_RUN));
endmodule

// File: rtl/ptimer_wave.sv
module ptimer_wave import ptimer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  tmr_mode_e        mode,
  input  tmr_state_e       state,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] reload,
  output logic             tmr_out
);
  localparam int EFF_W = CNT_W + 1;

  logic [EFF_W-1:0] eff_cnt, eff_rel, half;

  assign eff_cnt = {(count == '0), count};
  assign eff_rel = {(reload == '0), reload};
  assign half    = eff_rel >> 1;

  always_comb begin
    tmr_out = 1'b1;
    case (state)
      ST_RUN: begin
        case (mode)
          M_RATE:           tmr_out = (count != CNT_W'(1));
          M_SQUARE:         tmr_out = (eff_cnt > half);
          M_SWSTB, M_HWSTB: tmr_out = 1'b1;
          default:          tmr_out = 1'b0;
        endcase
      end
      ST_STROBE: tmr_out = 1'b0;
      default:   tmr_out = 1'b1;
    endcase
  end
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer import ptimer_pkg::*; #(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              cnt_en,
  input  logic              casc_in,
  input  logic              gate_in,
  output logic [CNT_W-1:0]  rd_count,
  output logic              tmr_out,
  output logic              irq
);
  tmr_mode_e        mode;
  tmr_state_e       state;
  logic             casc_sel, mode_wr, count_wr, sw_trig, tick, gate_rise;
  logic [CNT_W-1:0] reload, count;

  ptimer_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .casc_sel(casc_sel), .reload(reload),
    .mode_wr(mode_wr), .count_wr(count_wr), .sw_trig(sw_trig)
  );

  ptimer_tick u_tick (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .casc_in(casc_in), .gate_in(gate_in),
    .casc_sel(casc_sel), .mode(mode), .tick(tick), .gate_rise(gate_rise)
  );

  ptimer_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .reload(reload), .wr_data(wr_data),
    .mode_wr(mode_wr), .count_wr(count_wr), .sw_trig(sw_trig), .gate_rise(gate_rise),
    .tick(tick), .count(count), .state(state), .irq(irq)
  );

  ptimer_wave #(.CNT_W(CNT_W)) u_wave (
    .mode(mode), .state(state), .count(count), .reload(reload), .tmr_out(tmr_out)
  );

  assign rd_count = count;
endmodule

// File: tb/sim_prog_interval_timer.sv
`timescale 1ns/1ps
module sim_prog_interval_timer;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, cnt_en = 1'b1, casc_in = 1'b0, gate_in = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic [15:0] rd_count;
  logic        tmr_out, irq;

  prog_interval_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt_en(cnt_en), .casc_in(casc_in), .gate_in(gate_in),
    .rd_count(rd_count), .tmr_out(tmr_out), .irq(irq)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int          cyc;
    logic        o;
    logic        i;
    logic [15:0] c;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   cyc = 0, checks = 0, fails = 0;
  bit   done = 1'b0;

  task automatic expect_at(input int c, input logic o, input logic i, input int cnt, input string tag);
    exp_t e;
    e.cyc = c; e.o = o; e.i = i; e.c = cnt[15:0]; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    while (exp_q.size() > 0 && exp_q[0].cyc <= cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (e.cyc != cyc || tmr_out !== e.o || irq !== e.i || rd_count !== e.c) begin
        fails++;
        $display("FAIL %s cyc %0d: out=%b irq=%b count=%h expected out=%b irq=%b count=%h",
                 e.tag, cyc, tmr_out, irq, rd_count, e.o, e.i, e.c);
      end
    end
  end

  task automatic drv(input logic we, input logic [1:0] a, input logic [15:0] d,
                     input logic g, input logic cs, output int b);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; gate_in = g; casc_in = cs;
    b = cyc + 1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, output int b);
    drv(1'b1, a, d, 1'b0, 1'b0, b);
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(negedge clk);
      wr_en = 1'b0; gate_in = 1'b0; casc_in = 1'b0;
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    wait (cyc >= 150000);
    checks++; fails++;
    $display("FAIL watchdog: run hung at cyc %0d, expected completion", cyc);
    finish_run();
  end

  initial begin
    int b, p, m, g, h, e1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    expect_at(cyc + 1, 1'b1, 1'b0, 0, "R1 reset state");
    step(2);

    // terminal-count interrupt, N=5
    wr(2'd0, 16'h0000, b);
    wr(2'd1, 16'd5, p);
    expect_at(p,     1'b0, 1'b0, 5, "R2 load");
    expect_at(p + 4, 1'b0, 1'b0, 1, "R1 R2 live count");
    expect_at(p + 5, 1'b1, 1'b1, 0, "R2 terminal count");
    expect_at(p + 6, 1'b1, 1'b0, 0, "R2 irq one clock");
    step(8);

    // rate generator, N=3, then mode write stops it
    wr(2'd0, 16'h0002, b);
    wr(2'd1, 16'd3, p);
    expect_at(p,     1'b1, 1'b0, 3, "R4 load");
    expect_at(p + 1, 1'b1, 1'b0, 2, "R4 count");
    expect_at(p + 2, 1'b0, 1'b0, 1, "R4 low at 1");
    expect_at(p + 3, 1'b1, 1'b0, 3, "R4 reload");
    expect_at(p + 5, 1'b0, 1'b0, 1, "R4 second pulse");
    step(6);
    wr(2'd0, 16'h0002, m);
    expect_at(m,     1'b1, 1'b0, 3 - ((m - 1 - p) % 3), "R10 mode write holds count");
    expect_at(m + 2, 1'b1, 1'b0, 3 - ((m - 1 - p) % 3), "R10 channel stopped");
    step(4);

    // square wave, odd then even N
    wr(2'd0, 16'h0003, b);
    wr(2'd1, 16'd5, p);
    expect_at(p,     1'b1, 1'b0, 5, "R5 odd high");
    expect_at(p + 2, 1'b1, 1'b0, 3, "R5 odd extra high");
    expect_at(p + 3, 1'b0, 1'b0, 2, "R5 odd low");
    expect_at(p + 4, 1'b0, 1'b0, 1, "R5 odd low end");
    expect_at(p + 5, 1'b1, 1'b0, 5, "R5 odd reload");
    step(7);
    wr(2'd1, 16'd4, p);
    expect_at(p,     1'b1, 1'b0, 4, "R5 even high");
    expect_at(p + 1, 1'b1, 1'b0, 3, "R5 even high end");
    expect_at(p + 2, 1'b0, 1'b0, 2, "R5 even low");
    expect_at(p + 4, 1'b1, 1'b0, 4, "R5 even reload");
    step(6);

    // software strobe, N=3
    wr(2'd0, 16'h0004, b);
    wr(2'd1, 16'd3, p);
    expect_at(p,     1'b1, 1'b0, 3, "R6 load high");
    expect_at(p + 2, 1'b1, 1'b0, 1, "R6 counting");
    expect_at(p + 3, 1'b0, 1'b0, 0, "R6 strobe low");
    expect_at(p + 4, 1'b1, 1'b0, 0, "R6 back high");
    expect_at(p + 6, 1'b1, 1'b0, 0, "R6 stopped");
    step(8);

    // one-shot, N=4: software trigger, then gate retrigger
    wr(2'd0, 16'h0001, b);
    wr(2'd1, 16'd4, p);
    expect_at(p,     1'b1, 1'b0, 0, "R3 count write does not start");
    expect_at(p + 2, 1'b1, 1'b0, 0, "R3 still idle");
    step(3);
    wr(2'd2, 16'd0, p);
    expect_at(p,     1'b0, 1'b0, 4, "R3 software trigger");
    expect_at(p + 1, 1'b0, 1'b0, 3, "R3 running");
    step(1);
    drv(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, g);
    expect_at(g,     1'b0, 1'b0, 4, "R3 gate retrigger");
    expect_at(g + 3, 1'b0, 1'b0, 1, "R3 still low");
    expect_at(g + 4, 1'b1, 1'b0, 0, "R3 high at terminal");
    expect_at(g + 5, 1'b1, 1'b0, 0, "R3 stays high");
    step(7);

    // hardware strobe, N=2
    wr(2'd0, 16'h0005, b);
    wr(2'd1, 16'd2, p);
    expect_at(p, 1'b1, 1'b0, 0, "R7 count write does not start");
    step(2);
    drv(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, g);
    expect_at(g,     1'b1, 1'b0, 2, "R7 gate start");
    expect_at(g + 1, 1'b1, 1'b0, 1, "R7 counting");
    expect_at(g + 2, 1'b0, 1'b0, 0, "R7 strobe low");
    expect_at(g + 3, 1'b1, 1'b0, 0, "R7 back high");
    step(5);
    drv(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, h);
    expect_at(h,     1'b1, 1'b0, 2, "R7 second start");
    expect_at(h + 1, 1'b1, 1'b0, 1, "R7 second counting");
    step(1);
    drv(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, h);
    expect_at(h,     1'b1, 1'b0, 2, "R7 retrigger before strobe");
    expect_at(h + 1, 1'b1, 1'b0, 1, "R7 retrigger counting");
    expect_at(h + 2, 1'b0, 1'b0, 0, "R7 retrigger strobe");
    expect_at(h + 3, 1'b1, 1'b0, 0, "R7 retrigger done");
    step(7);

    // event counter, N=3
    wr(2'd0, 16'h0006, b);
    wr(2'd1, 16'd3, p);
    expect_at(p,     1'b0, 1'b0, 3, "R9 load");
    expect_at(p + 4, 1'b0, 1'b0, 3, "R9 clock enable ignored");
    step(5);
    drv(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, e1);
    expect_at(e1, 1'b0, 1'b0, 2, "R9 first event");
    step(2);
    drv(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, e1);
    expect_at(e1, 1'b0, 1'b0, 1, "R9 second event");
    step(2);
    drv(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, e1);
    expect_at(e1,     1'b1, 1'b1, 0, "R9 Nth event irq");
    expect_at(e1 + 1, 1'b1, 1'b0, 0, "R9 irq ends");
    step(3);

    // cascade source with rate generator, N=2
    wr(2'd0, 16'h000A, b);
    wr(2'd1, 16'd2, p);
    expect_at(p,     1'b1, 1'b0, 2, "R8 cascade load");
    expect_at(p + 3, 1'b1, 1'b0, 2, "R8 clock enable not used in cascade");
    step(4);
    drv(1'b0, 2'd0, 16'd0, 1'b0, 1'b1, g);
    expect_at(g,     1'b0, 1'b0, 1, "R8 cascade tick");
    expect_at(g + 2, 1'b0, 1'b0, 1, "R8 holds between cascade ticks");
    step(3);
    drv(1'b0, 2'd0, 16'd0, 1'b0, 1'b1, g);
    expect_at(g, 1'b1, 1'b0, 2, "R8 cascade reload");
    step(2);

    // clock enable gating in mode 0
    wr(2'd0, 16'h0000, b);
    cnt_en = 1'b0;
    wr(2'd1, 16'd3, p);
    expect_at(p,     1'b0, 1'b0, 3, "R8 load without enable");
    expect_at(p + 3, 1'b0, 1'b0, 3, "R8 holds without enable");
    step(4);
    @(negedge clk);
    cnt_en = 1'b1;
    g = cyc + 1;
    expect_at(g,     1'b0, 1'b0, 2, "R8 enable resumes");
    expect_at(g + 2, 1'b1, 1'b1, 0, "R2 R8 terminal");
    expect_at(g + 3, 1'b1, 1'b0, 0, "R2 irq ends");
    step(4);

    // start value zero means 65536
    wr(2'd1, 16'd0, p);
    expect_at(p,         1'b0, 1'b0, 0,       "R11 load zero");
    expect_at(p + 1,     1'b0, 1'b0, 16'hFFFF, "R11 wraps to FFFF");
    expect_at(p + 65535, 1'b0, 1'b0, 1,       "R11 one before terminal");
    expect_at(p + 65536, 1'b1, 1'b1, 0,       "R11 terminal after 65536");
    step(65540);

    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard: %0d expected items left, expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule